// File: doc/BRIEF.md
# Prescaled PWM Timer with Grouped Parameter Update

This block produces one pulse-width-modulated output from a clock that is first slowed by a power-of-two prescaler. Two 32-bit registers are reached through a plain write-enable, address and data port. The control word holds these fields:

- a run bit;
- a five-bit prescaler exponent, split across a four-bit field and a separate low bit;
- a freeze bit.

The counter word holds a 10-bit period and a 10-bit high time.

Period, high time and exponent are double-buffered. Writes go into a shadow copy. The shadow copy moves into the active copy as one group, and only when this is safe: at once while the channel is idle, otherwise on the last prescaled tick of a period.

Software sets the freeze bit, writes the new values and then clears the bit. This way a half-updated combination never reaches the output. When a register is read, it returns the shadow contents.

Top module: `pwm_prescaled`

## Requirements
- R1: The control word is at byte offset 0x00. Its bit 0 is run, bit 4 a spare flag with no effect, bit 11 freeze, bit 15 exponent bit 0, and bits 19:16 exponent bits 4:1. The counter word is at offset 0x04, with the period in bits 25:16 and the high time in bits 9:0. Reads return the last written values, other bits read 0, and other offsets read 0.
- R2: After reset both words read 0 and the output is low.
- R3: While running with period P and high time H, the prescaled counter starts at 0 in the first cycle after run is written to 1. The output is high for counts 0 to H-1 and low for counts H to P-1, and the counter then wraps to 0.
- R4: The counter advances once every 2^n input clocks, where n is the exponent. An exponent above 24 acts as 24.
- R5: When H is greater than or equal to P, the output stays high while running.
- R6: When run is 0, or the active P is 0, or the active H is 0, the output is low and the counter and prescaler are held at zero. This takes effect from the cycle after the write.
- R7: While freeze is 1, writes change only the shadow values. The active period, high time and exponent stay unchanged.
- R8: When a running channel has pending values and freeze is 0, the period, high time and exponent all take effect at the next period boundary. The counter restarts at 0 with the new values.
- R9: While idle (the condition in R6), pending values become active on the clock edge after the write that leaves freeze at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 1 | Active-high PWM output |

## Verification
The hardest situation to reach is a frozen update on a running channel. Here the new period must stay out of use through several boundaries and then switch in on exactly one edge. The stimulus enables a 4-count period, sets freeze, writes a 6-count period and waits five cycles. It then clears freeze at a known phase of the count, so the switch must land on cycle 12. The scoreboard compares every cycle on both sides of that switch. A second sequence writes under freeze while the channel is idle and then clears freeze. The wave seen after the channel is enabled must match the new values.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int unsigned OFS_CTRL  = 0;
    localparam int unsigned OFS_COUNT = 4;

    localparam int unsigned BIT_RUN    = 0;
    localparam int unsigned BIT_SPARE  = 4;
    localparam int unsigned BIT_FREEZE = 11;
    localparam int unsigned BIT_EXPLO  = 15;
    localparam int unsigned POS_EXPHI  = 16;
    localparam int unsigned EXPHI_W    = 4;
    localparam int unsigned EXP_W      = EXPHI_W + 1;

    localparam int unsigned POS_PERIOD = 16;
    localparam int unsigned POS_HIGH   = 0;

    typedef struct packed {
        logic run;
        logic spare;
        logic freeze;
    } ctrl_flags_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int unsigned CNT_W  = 10,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              commit,
    output logic [31:0]       rdata,
    output ctrl_flags_t       flags,
    output logic              pending,
    output logic [CNT_W-1:0]  per_act,
    output logic [CNT_W-1:0]  high_act,
    output logic [EXP_W-1:0]  exp_act
);
    typedef struct packed {
        ctrl_flags_t      flags;
        logic [CNT_W-1:0] per_sh;
        logic [CNT_W-1:0] high_sh;
        logic [EXP_W-1:0] exp_sh;
        logic [CNT_W-1:0] per_ac;
        logic [CNT_W-1:0] high_ac;
        logic [EXP_W-1:0] exp_ac;
        logic             pend;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic hit_ctrl, hit_count;
    assign hit_ctrl  = (addr == ADDR_W'(OFS_CTRL));
    assign hit_count = (addr == ADDR_W'(OFS_COUNT));

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.per_ac  = st_q.per_sh;
            st_d.high_ac = st_q.high_sh;
            st_d.exp_ac  = st_q.exp_sh;
            st_d.pend    = 1'b0;
        end
        if (wr_en && hit_ctrl) begin
            st_d.flags.run    = wdata[BIT_RUN];
            st_d.flags.spare  = wdata[BIT_SPARE];
            st_d.flags.freeze = wdata[BIT_FREEZE];
            st_d.exp_sh       = {wdata[POS_EXPHI +: EXPHI_W], wdata[BIT_EXPLO]};
            st_d.pend         = 1'b1;
        end
        if (wr_en && hit_count) begin
            st_d.per_sh  = wdata[POS_PERIOD +: CNT_W];
            st_d.high_sh = wdata[POS_HIGH +: CNT_W];
            st_d.pend    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata[BIT_RUN]                = st_q.flags.run;
            rdata[BIT_SPARE]              = st_q.flags.spare;
            rdata[BIT_FREEZE]             = st_q.flags.freeze;
            rdata[BIT_EXPLO]              = st_q.exp_sh[0];
            rdata[POS_EXPHI +: EXPHI_W]   = st_q.exp_sh[EXP_W-1:1];
        end else if (hit_count) begin
            rdata[POS_PERIOD +: CNT_W] = st_q.per_sh;
            rdata[POS_HIGH +: CNT_W]   = st_q.high_sh;
        end
    end

    assign flags    = st_q.flags;
    assign pending  = st_q.pend;
    assign per_act  = st_q.per_ac;
    assign high_act = st_q.high_ac;
    assign exp_act  = st_q.exp_ac;
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
#(
    parameter int unsigned MAX_EXP = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [EXP_W-1:0] exp_code,
    output logic             tick
);
    localparam int unsigned PRE_W = (MAX_EXP > 0) ? MAX_EXP : 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;

    logic [EXP_W-1:0] eff_exp;
    logic [PRE_W-1:0] limit;

    always_comb begin
        eff_exp = (32'(exp_code) > MAX_EXP) ? EXP_W'(MAX_EXP) : exp_code;
        limit   = {PRE_W{1'b1}} >> (PRE_W - 32'(eff_exp));
    end

    assign tick = !clear && (st_q.pre == limit);

    always_comb begin
        st_d = st_q;
        if (clear || tick) st_d.pre = '0;
        else               st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] high_len,
    output logic [CNT_W-1:0] count,
    output logic             boundary,
    output logic             wave
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } wave_state_t;

    wave_state_t st_d, st_q;

    assign boundary = tick && (st_q.cnt == period - 1'b1);

    always_comb begin
        st_d = st_q;
        if (clear)         st_d.cnt = '0;
        else if (boundary) st_d.cnt = '0;
        else if (tick)     st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign wave  = !clear && (st_q.cnt < high_len);
endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
    import pwm_pkg::*;
#(
    parameter int unsigned CNT_W   = 10,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned MAX_EXP = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out
);
    ctrl_flags_t      flags;
    logic             pending;
    logic [CNT_W-1:0] per_act, high_act, count;
    logic [EXP_W-1:0] exp_act;
    logic             idle, tick, boundary, commit;

    assign idle   = !flags.run || (per_act == '0) || (high_act == '0);
    assign commit = pending && !flags.freeze && (idle || boundary);

    pwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .commit(commit), .rdata(bus_rdata),
        .flags(flags), .pending(pending), .per_act(per_act),
        .high_act(high_act), .exp_act(exp_act)
    );

    pwm_prescaler #(.MAX_EXP(MAX_EXP)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(idle), .exp_code(exp_act), .tick(tick)
    );

    pwm_wave #(.CNT_W(CNT_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .clear(idle), .tick(tick),
        .period(per_act), .high_len(high_act), .count(count),
        .boundary(boundary), .wave(pwm_out)
    );
endmodule

// File: rtl/pwm_prescaled_chk.sv
module pwm_prescaled_chk #(
    parameter int unsigned CNT_W  = 10,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              freeze,
    input logic [CNT_W-1:0]  per_act,
    input logic [CNT_W-1:0]  high_act,
    input logic [4:0]        exp_act,
    input logic [CNT_W-1:0]  count,
    input logic              pwm_out,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata
);
    logic running;
    assign running = run && (per_act != '0) && (high_act != '0);

    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !pwm_out);

    assert_full_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && high_act >= per_act) |-> pwm_out);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (count < per_act));

    assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> ($stable(per_act) && $stable(high_act) && $stable(exp_act)));

    assert_ctrl_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(0)) |-> ((bus_rdata & ~32'h000F_8811) == 32'h0));

    assert_count_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(4)) |-> ((bus_rdata & ~32'h03FF_03FF) == 32'h0));
endmodule

bind pwm_prescaled pwm_prescaled_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(flags.run), .freeze(flags.freeze),
    .per_act(per_act), .high_act(high_act), .exp_act(exp_act),
    .count(count), .pwm_out(pwm_out), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/pwm_prescaled_test.sv
module pwm_prescaled_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    bit    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    pwm_prescaled uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    function automatic bit model(int i, int p, int h, int n);
        return ((i >> n) % p) < h;
    endfunction

    task automatic push_wave(int p, int h, int n, int count, string tag);
        for (int i = 0; i < count; i++) begin
            exp_q.push_back(model(i, p, h, n));
            tag_q.push_back(tag);
        end
    endtask

    task automatic push_const(bit v, int count, string tag);
        for (int i = 0; i < count; i++) begin
            exp_q.push_back(v);
            tag_q.push_back(tag);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_check(logic [7:0] a, logic [31:0] expv, string tag);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== expv) begin
            errors++;
            $display("FAIL %s read 0x%02h actual=0x%08h expected=0x%08h", tag, a, bus_rdata, expv);
        end
    endtask

    task automatic out_check(bit expv, string tag);
        checks++;
        if (pwm_out !== expv) begin
            errors++;
            $display("FAIL %s pwm_out actual=%0b expected=%0b", tag, pwm_out, expv);
        end
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    // scoreboard monitor: one expected item per cycle, sampled mid-high phase
    initial begin
        bit    e;
        string t;
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (pwm_out !== e) begin
                    errors++;
                    $display("FAIL %s at %0t pwm_out actual=%0b expected=%0b", t, $time, pwm_out, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        out_check(1'b0, "R2 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        rd_check(8'h00, 32'h0, "R2 ctrl after reset");
        rd_check(8'h04, 32'h0, "R2 count after reset");
        out_check(1'b0, "R2 after reset");

        // R3 basic waveform, period 5, high 3, no prescale
        wr(8'h04, (32'd5 << 16) | 32'd3);
        repeat (2) @(negedge clk);
        push_wave(5, 3, 0, 30, "R3 P5 H3");
        wr(8'h00, 32'h1);
        drain();
        push_const(1'b0, 4, "R6 after disable");
        wr(8'h00, 32'h0);
        drain();

        // R4 prescaler exponent 3 (both fields set)
        wr(8'h04, (32'd3 << 16) | 32'd1);
        wr(8'h00, 32'h0001_8000);
        repeat (2) @(negedge clk);
        push_wave(3, 1, 3, 60, "R4 exp3");
        wr(8'h00, 32'h0001_8001);
        drain();
        push_const(1'b0, 3, "R6 disable");
        wr(8'h00, 32'h0);
        drain();

        // R4 prescaler exponent 2 (upper field only)
        wr(8'h00, 32'h0001_0000);
        repeat (2) @(negedge clk);
        push_wave(3, 1, 2, 30, "R4 exp2");
        wr(8'h00, 32'h0001_0001);
        drain();
        wr(8'h00, 32'h0);

        // R5 high time above period
        wr(8'h04, (32'd3 << 16) | 32'd5);
        repeat (2) @(negedge clk);
        push_const(1'b1, 20, "R5 H>=P");
        wr(8'h00, 32'h1);
        drain();
        wr(8'h00, 32'h0);

        // R6 zero high time, then zero period
        wr(8'h04, (32'd4 << 16));
        repeat (2) @(negedge clk);
        push_const(1'b0, 10, "R6 high zero");
        wr(8'h00, 32'h1);
        drain();
        wr(8'h00, 32'h0);
        wr(8'h04, 32'd2);
        repeat (2) @(negedge clk);
        push_const(1'b0, 10, "R6 period zero");
        wr(8'h00, 32'h1);
        drain();
        wr(8'h00, 32'h0);

        // R7/R8 frozen update on a running channel: switch expected on cycle 12
        wr(8'h04, (32'd4 << 16) | 32'd2);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 36; i++) begin
            if (i < 12) begin
                exp_q.push_back((i % 4) < 2);
                tag_q.push_back("R7 old values kept");
            end else begin
                exp_q.push_back(((i - 12) % 6) < 3);
                tag_q.push_back("R8 grouped switch");
            end
        end
        wr(8'h00, 32'h1);
        wr(8'h00, 32'h801);
        wr(8'h04, (32'd6 << 16) | 32'd3);
        rd_check(8'h04, 32'h0006_0003, "R1 shadow readback");
        repeat (5) @(negedge clk);
        wr(8'h00, 32'h1);
        drain();
        wr(8'h00, 32'h0);

        // R9 idle commit on freeze clear
        wr(8'h00, 32'h800);
        wr(8'h04, (32'd2 << 16) | 32'd1);
        repeat (3) @(negedge clk);
        wr(8'h00, 32'h0);
        repeat (2) @(negedge clk);
        push_wave(2, 1, 0, 16, "R9 idle commit");
        wr(8'h00, 32'h1);
        drain();
        wr(8'h00, 32'h0);

        // R1 field mask and unmapped offset
        wr(8'h00, 32'hFFFF_FFFF);
        rd_check(8'h00, 32'h000F_8811, "R1 ctrl mask");
        wr(8'h04, 32'hFFFF_FFFF);
        rd_check(8'h04, 32'h03FF_03FF, "R1 count mask");
        rd_check(8'h08, 32'h0, "R1 unmapped");
        wr(8'h00, 32'h0);
        rd_check(8'h00, 32'h000F_8000 & 32'h0, "R1 ctrl cleared");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule